// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between an instruction fetch stage and eight functional units of a very-long-instruction-word core. It takes in one aligned fetch packet of eight 32-bit instructions at a time. Each instruction comes with a 3-bit unit code on a side input. The block then walks the packet from the lowest address upward. It cuts the packet into execute packets by following the chain bit in bit 0 of each instruction. Exactly one execute packet leaves per clock, spread across eight per-unit output slots.

A set chain bit on an instruction means the next instruction joins the same cycle's group. A clear bit closes the group. A group never reaches past the end of its fetch packet. While a packet is still being split, the fetch side is held off. When two instructions of one group name the same unit, only the lower-addressed one issues and an error flag is raised for that cycle.

Top module: `vliw_ep_dispatch`

## Requirements
- R1: A fetch packet (instruction i in bits [32i+31:32i], its unit code in bits [3i+2:3i] of the unit input) is captured when `fp_valid` and `fp_ready` are both high at a rising clock edge, and the first group is visible on the slot outputs in the following cycle.
- R2: Bit 0 of each instruction is its chain bit: when it is 1, the next-higher instruction issues in the same cycle; when it is 0, the next instruction issues one cycle later.
- R3: Groups issue one per cycle in ascending instruction order, with no idle cycle between the groups of one packet.
- R4: The chain bit of instruction 7 is ignored. A group ends at instruction 7, and the cycle after the final group, with no new packet accepted, shows all slot-valid bits at 0.
- R5: `fp_ready` is 1 when no packet is held, or when the final group of the held packet is issuing; otherwise it is 0, and an offered packet has no effect on the outputs.
- R6: An issued instruction appears on the slot whose index equals its unit code (0 to 7), with that slot's valid bit at 1; slots not used by the group have valid 0.
- R7: If several instructions of one group carry the same unit code, `conflict` is 1 in that cycle and only the lowest-addressed of them appears on that slot.
- R8: With `rst_n` low at a rising edge (synchronous, active low), the held packet is dropped: afterwards all slot-valid bits are 0, `conflict` is 0 and `fp_ready` is 1.
- R9: A packet accepted in the cycle of the previous packet's final group issues its first group in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Block can take a fetch packet this cycle |
| fp_data | input | 256 | Eight instructions, instruction 0 in the low word |
| fp_units | input | 24 | Eight 3-bit unit codes, instruction 0 in the low bits |
| slot_valid | output | 8 | Per-unit issue strobe for the current group |
| slot_instr | output | 256 | Per-unit instruction word, slot 0 in the low word |
| conflict | output | 1 | Two instructions of the current group named one unit |

## Verification
The bench builds the block with its default widths: eight slots of 32-bit instructions and 3-bit unit codes. At this size a group can cover the whole packet, which brings the eight-wide issue into reach. It also makes every unit code usable, so the reversed and fully clashing unit maps can be run. The full length of the back-pressure window can be observed as well, from a packet of eight single-instruction groups up to a back-to-back handover.

// File: rtl/vliw_ep_pkg.sv
// Shared definitions for the execute packet dispatcher.
// Assumes nothing beyond plain SystemVerilog types.
package vliw_ep_pkg;

    // Dispatcher occupancy: no packet held, or a packet being split.
    typedef enum logic {
        EP_IDLE  = 1'b0,
        EP_ISSUE = 1'b1
    } ep_state_t;

endpackage

// File: rtl/vliw_ep_group_find.sv
// Finds the execute group that starts at the scan pointer.
// Assumes the pointer addresses a held instruction; a group always ends
// at the last instruction of the packet even if its chain bit is set.
module vliw_ep_group_find #(
    parameter int unsigned NUM_SLOTS = 8,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [IDX_W-1:0]     start_idx,
    input  logic [NUM_SLOTS-1:0] chain_bits,
    output logic [NUM_SLOTS-1:0] grp_mask,
    output logic [IDX_W-1:0]     last_idx,
    output logic                 is_final
);

    logic closed;

    // Scan upward from the pointer until a clear chain bit closes the group.
    always_comb begin
        closed   = 1'b0;
        grp_mask = '0;
        last_idx = IDX_W'(NUM_SLOTS - 1);
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i >= int'(start_idx) && !closed) begin
                grp_mask[i] = 1'b1;
                if (!chain_bits[i]) begin
                    closed   = 1'b1;
                    last_idx = IDX_W'(i);
                end
            end
        end
        is_final = (last_idx == IDX_W'(NUM_SLOTS - 1));
    end

endmodule

// File: rtl/vliw_ep_slot_route.sv
// Routes the members of one execute group onto per-unit slots.
// Assumes unit codes index slots directly; on a repeated unit code the
// lowest-addressed member wins and the clash is flagged.
module vliw_ep_slot_route #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned INSTR_W   = 32,
    localparam int unsigned SEL_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]         grp_mask,
    input  logic [NUM_SLOTS*INSTR_W-1:0] instrs,
    input  logic [NUM_SLOTS*SEL_W-1:0]   units,
    output logic [NUM_SLOTS-1:0]         slot_valid,
    output logic [NUM_SLOTS*INSTR_W-1:0] slot_instr,
    output logic                         conflict
);

    logic [SEL_W-1:0] unit_sel;

    // Claim each unit for the first group member that names it.
    always_comb begin
        slot_valid = '0;
        slot_instr = '0;
        conflict   = 1'b0;
        unit_sel   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (grp_mask[i]) begin
                unit_sel = units[i*SEL_W +: SEL_W];
                if (slot_valid[unit_sel]) begin
                    conflict = 1'b1;
                end else begin
                    slot_valid[unit_sel] = 1'b1;
                    slot_instr[int'(unit_sel)*INSTR_W +: INSTR_W] =
                        instrs[i*INSTR_W +: INSTR_W];
                end
            end
        end
    end

endmodule

// File: rtl/vliw_ep_dispatch.sv
// Execute packet dispatcher: holds one fetch packet and issues one
// chained group of its instructions per cycle onto per-unit slots.
// Assumes fetch packets arrive aligned and complete; bit 0 of every
// instruction is its chain bit.
module vliw_ep_dispatch #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned INSTR_W   = 32,
    localparam int unsigned SEL_W    = $clog2(NUM_SLOTS),
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
    localparam int unsigned PKT_W    = NUM_SLOTS * INSTR_W,
    localparam int unsigned UNITS_W  = NUM_SLOTS * SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fp_valid,
    output logic                 fp_ready,
    input  logic [PKT_W-1:0]     fp_data,
    input  logic [UNITS_W-1:0]   fp_units,
    output logic [NUM_SLOTS-1:0] slot_valid,
    output logic [PKT_W-1:0]     slot_instr,
    output logic                 conflict
);

    import vliw_ep_pkg::*;

    ep_state_t            state_q;
    logic [PKT_W-1:0]     pkt_q;
    logic [UNITS_W-1:0]   units_q;
    logic [IDX_W-1:0]     ptr_q;
    logic [NUM_SLOTS-1:0] chain_bits;
    logic [NUM_SLOTS-1:0] grp_mask;
    logic [NUM_SLOTS-1:0] live_mask;
    logic [IDX_W-1:0]     last_idx;
    logic                 is_final;
    logic                 accept;

    // Pull the chain bit out of every held instruction.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chain
        assign chain_bits[g] = pkt_q[g*INSTR_W];
    end

    vliw_ep_group_find #(
        .NUM_SLOTS (NUM_SLOTS)
    ) find_i (
        .start_idx  (ptr_q),
        .chain_bits (chain_bits),
        .grp_mask   (grp_mask),
        .last_idx   (last_idx),
        .is_final   (is_final)
    );

    // Only a held packet produces a group.
    assign live_mask = (state_q == EP_ISSUE) ? grp_mask : '0;

    vliw_ep_slot_route #(
        .NUM_SLOTS (NUM_SLOTS),
        .INSTR_W   (INSTR_W)
    ) route_i (
        .grp_mask   (live_mask),
        .instrs     (pkt_q),
        .units      (units_q),
        .slot_valid (slot_valid),
        .slot_instr (slot_instr),
        .conflict   (conflict)
    );

    // Take a new packet when empty or while the last group leaves.
    assign fp_ready = (state_q == EP_IDLE) || is_final;
    assign accept   = fp_valid && fp_ready;

    // Hold the packet and step the scan pointer past each issued group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EP_IDLE;
            pkt_q   <= '0;
            units_q <= '0;
            ptr_q   <= '0;
        end else if (accept) begin
            state_q <= EP_ISSUE;
            pkt_q   <= fp_data;
            units_q <= fp_units;
            ptr_q   <= '0;
        end else if (state_q == EP_ISSUE) begin
            if (is_final) begin
                state_q <= EP_IDLE;
                ptr_q   <= '0;
            end else begin
                ptr_q <= last_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vliw_ep_dispatch_chk.sv
// Port-level properties of the dispatcher, attached by bind.
// Assumes the reset is synchronous and active low.
module vliw_ep_dispatch_chk #(
    parameter int unsigned NUM_SLOTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fp_valid,
    input logic                 fp_ready,
    input logic [NUM_SLOTS-1:0] slot_valid,
    input logic                 conflict
);

    // A reset edge leaves no group on the slots and the input open.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (slot_valid == '0 && fp_ready && !conflict));

    // Back-pressure only while a group is actually issuing.
    p_stall_has_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_ready |-> (slot_valid != '0));

    // A clash always loses at least one member, so not all slots fill.
    p_clash_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($countones(slot_valid) < NUM_SLOTS));

    // An accepted packet issues its first group in the next cycle.
    p_accept_issues_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fp_ready) |=> (slot_valid != '0));

    // With the input open and nothing offered, the next cycle is quiet.
    p_packet_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_ready && !fp_valid) |=> (slot_valid == '0 && !conflict));

endmodule

bind vliw_ep_dispatch vliw_ep_dispatch_chk #(
    .NUM_SLOTS (NUM_SLOTS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fp_valid   (fp_valid),
    .fp_ready   (fp_ready),
    .slot_valid (slot_valid),
    .conflict   (conflict)
);

// File: tb/vliw_ep_dispatch_tb_top.sv
// Self-checking bench: table-driven packets, then directed corner cases.
module vliw_ep_dispatch_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fp_valid = 1'b0;
    logic         fp_ready;
    logic [255:0] fp_data = '0;
    logic [23:0]  fp_units = '0;
    logic [7:0]   slot_valid;
    logic [255:0] slot_instr;
    logic         conflict;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    vliw_ep_dispatch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_valid   (fp_valid),
        .fp_ready   (fp_ready),
        .fp_data    (fp_data),
        .fp_units   (fp_units),
        .slot_valid (slot_valid),
        .slot_instr (slot_instr),
        .conflict   (conflict)
    );

    // {group count[3:0], chain mask[7:0], unit codes[23:0]}
    localparam logic [35:0] VEC [6] = '{
        {4'd8, 8'h00, 24'hFAC688},  // singles, identity units
        {4'd1, 8'h7F, 24'hFAC688},  // one eight-wide group
        {4'd1, 8'hFF, 24'hFAC688},  // last chain bit ignored
        {4'd4, 8'h55, 24'h053977},  // pairs, reversed units
        {4'd5, 8'h07, 24'h000000},  // four-way clash on unit 0
        {4'd4, 8'h3C, 24'h8D1D4F}   // mixed chain, scattered units
    };

    function automatic logic [31:0] mk_instr(int k, int i, bit p);
        return {8'(k), 8'(i), 15'h2A5A, p};
    endfunction

    function automatic logic [255:0] mk_packet(int k, logic [7:0] pm);
        logic [255:0] d = '0;
        for (int i = 0; i < 8; i++) d[i*32 +: 32] = mk_instr(k, i, pm[i]);
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference grouping from the requirements, starting at instruction s.
    task automatic model(input logic [7:0] pm, input logic [23:0] un,
                         input int k, input int s, output int e,
                         output logic [7:0] ev, output logic [255:0] ei,
                         output logic ec);
        ev = '0; ei = '0; ec = 1'b0; e = 7;
        for (int i = s; i < 8; i++) begin
            int u;
            u = int'(un[i*3 +: 3]);
            if (ev[u]) ec = 1'b1;
            else begin
                ev[u] = 1'b1;
                ei[u*32 +: 32] = mk_instr(k, i, pm[i]);
            end
            if (!pm[i] || i == 7) begin
                e = i;
                break;
            end
        end
    endtask

    // Compare the slots at a negedge against the model group from s.
    task automatic check_group(input logic [7:0] pm, input logic [23:0] un,
                               input int k, input int s, output int e);
        logic [7:0]   ev;
        logic [255:0] ei;
        logic         ec;
        model(pm, un, k, s, e, ev, ei, ec);
        check(slot_valid === ev, "R2", "slot_valid", 256'(slot_valid), 256'(ev));
        check(slot_instr === ei, "R6", "slot_instr", slot_instr, ei);
        check(conflict === ec, "R7", "conflict", 256'(conflict), 256'(ec));
        check(fp_ready === (e == 7), "R5", "fp_ready", 256'(fp_ready), 256'(e == 7));
    endtask

    initial begin
        int e;
        int ng;
        repeat (3) @(negedge clk);
        check(slot_valid === 8'h00, "R8", "reset slot_valid", 256'(slot_valid), 256'h0);
        check(fp_ready === 1'b1, "R8", "reset fp_ready", 256'(fp_ready), 256'h1);
        check(conflict === 1'b0, "R8", "reset conflict", 256'(conflict), 256'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 capture, R3 one group per cycle, R4 packet end.
        for (int v = 0; v < 6; v++) begin
            logic [7:0]  pm;
            logic [23:0] un;
            int          s;
            pm = VEC[v][31:24];
            un = VEC[v][23:0];
            fp_valid = 1'b1;
            fp_data  = mk_packet(v, pm);
            fp_units = un;
            check(fp_ready === 1'b1, "R1", "idle ready", 256'(fp_ready), 256'h1);
            @(negedge clk);
            fp_valid = 1'b0;
            fp_data  = '0;
            s = 0; ng = 0;
            forever begin
                check_group(pm, un, v, s, e);
                ng++;
                if (e == 7) break;
                s = e + 1;
                @(negedge clk);
            end
            check(ng == int'(VEC[v][35:32]), "R3", "group count",
                  256'(ng), 256'(VEC[v][35:32]));
            @(negedge clk);
            check(slot_valid === 8'h00, "R4", "quiet after packet",
                  256'(slot_valid), 256'h0);
        end

        // Back-pressure and back-to-back handover: R5, R9.
        fp_valid = 1'b1;
        fp_data  = mk_packet(20, 8'h00);
        fp_units = 24'hFAC688;
        @(negedge clk);
        fp_data  = mk_packet(21, 8'h7F);
        fp_units = 24'h053977;
        for (int s = 0; s < 8; s++) begin
            check_group(8'h00, 24'hFAC688, 20, s, e);
            @(negedge clk);
        end
        fp_valid = 1'b0;
        check_group(8'h7F, 24'h053977, 21, 0, e);
        check(slot_valid === 8'hFF, "R9", "handover full group",
              256'(slot_valid), 256'hFF);
        @(negedge clk);
        check(slot_valid === 8'h00, "R4", "quiet after handover",
              256'(slot_valid), 256'h0);

        // Reset in the middle of a packet: R8.
        fp_valid = 1'b1;
        fp_data  = mk_packet(30, 8'h00);
        fp_units = 24'hFAC688;
        @(negedge clk);
        fp_valid = 1'b0;
        @(negedge clk);
        check_group(8'h00, 24'hFAC688, 30, 1, e);
        rst_n = 1'b0;
        @(negedge clk);
        check(slot_valid === 8'h00, "R8", "mid reset slot_valid", 256'(slot_valid), 256'h0);
        check(fp_ready === 1'b1, "R8", "mid reset fp_ready", 256'(fp_ready), 256'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(slot_valid === 8'h00, "R8", "held packet dropped", 256'(slot_valid), 256'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule